// File: doc/BRIEF.md
# Manual Press Qualifier

This block sits between a push switch that pulls a line to supply and the power-gating controller. The raw level passes through a flop synchronizer. It is then debounced on a slow timing strobe, and the block decides whether the press lasted long enough to count. The strobe is normally one millisecond. The switch can be used to power a gated load by hand. It also affects the startup phase in which the gating interval is measured.

After a press is accepted, the block asks the controller to keep its interval counters cleared for as long as the switch stays down. Holding the switch longer therefore extends the on-time. A press made while the startup measurement runs aborts that measurement and asks for a restart once the switch is released. A press is ignored if the gated load is already powered when the press is judged.

Top module: `manual_press_qualifier`

## Requirements
- R1: While `rst_n` is low, and until the first qualifying input after it, `press_pulse`, `trig_held`, `hold_timers`, `abort_meas` and `restart_meas` are all 0.
- R2: `trig_held` changes only after the synchronized input has disagreed with it on `DEBOUNCE_TICKS` consecutive strobes (default 3). This applies to both the rising and the falling direction, so a one-strobe excursion either way leaves `trig_held` unchanged.
- R3: A press is accepted when `MIN_HIGH_TICKS` strobes (default 20) with `trig_held` high are counted inside a window of `WINDOW_TICKS` strobes (default 30) that opens when `trig_held` rises. A press that ends before that count, or whose high strobes are split by a release so that they fall short when the window closes, produces no `press_pulse`.
- R4: `press_pulse` is asserted in the clock cycle right after the strobe that brings the high count to `MIN_HIGH_TICKS`. It follows the `trig_held` rise by exactly that many strobes, well inside a 10-strobe budget after qualification.
- R5: `hold_timers` is 1 from the accepted press until `trig_held` returns low, however long that takes, and 0 at all other times.
- R6: If `load_on` is 1 when the high count completes, the press is dropped: no `press_pulse` is produced and `hold_timers` stays 0.
- R7: When `trig_held` is high while `measuring` is 1, `abort_meas` is 1 and no press is accepted. When `trig_held` then falls, `abort_meas` returns to 0 and `restart_meas` pulses for exactly one clock cycle.
- R8: `press_pulse` is 1 for a single clock cycle per accepted press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timing strobe (one millisecond) |
| trig_raw | input | 1 | Asynchronous switch level, 1 = pressed |
| measuring | input | 1 | 1 while power-on reset or interval measurement is in progress |
| load_on | input | 1 | 1 when the gate already powers the load |
| press_pulse | output | 1 | One-cycle pulse for an accepted press |
| trig_held | output | 1 | Debounced switch level |
| hold_timers | output | 1 | Keep interval counters cleared; falls on release |
| abort_meas | output | 1 | Abort the running interval measurement |
| restart_meas | output | 1 | One-cycle request to restart the measurement |

## Verification
The bench uses one-strobe glitches in both directions to check the debouncer. A debouncer that follows every sample would show a spurious `trig_held` edge. It times the press pulse against the debounced rise in strobes, which catches an off-by-one in the high count or a window opened on the wrong event. A press split by a long release is used to expose a design that restarts its counts on each rise or ignores the window, because such a design would accept a press the rules reject. Presses with the load already powered, and presses during measurement, show whether the block wrongly arms the counters or accepts the press, and whether it forgets to request a measurement restart on release.

// File: rtl/mpq_pkg.sv
package mpq_pkg;
   typedef enum logic [2:0] {
      Q_IDLE    = 3'd0,
      Q_OBSERVE = 3'd1,
      Q_ARMED   = 3'd2,
      Q_SPENT   = 3'd3,
      Q_ABORT   = 3'd4
   } qual_state_t;
endpackage

// File: rtl/mpq_sync.sv
module mpq_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mpq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RST_VAL;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= RST_VAL;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mpq_debounce.sv
module mpq_debounce #(
   parameter int DB_TICKS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic din,
   output logic level
);
   localparam int CW = (DB_TICKS < 2) ? 1 : $clog2(DB_TICKS + 1);

   if (DB_TICKS < 1) begin : g_bad_db
      $error("mpq_debounce: DB_TICKS must be at least 1");
   end

   logic [CW-1:0] disagree_cnt;
   logic          level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         disagree_cnt <= '0;
         level_q      <= 1'b0;
      end else if (tick) begin
         if (din != level_q) begin
            if (disagree_cnt == CW'(DB_TICKS - 1)) begin
               level_q      <= din;
               disagree_cnt <= '0;
            end else begin
               disagree_cnt <= disagree_cnt + 1'b1;
            end
         end else begin
            disagree_cnt <= '0;
         end
      end
   end

   assign level = level_q;

   // R2: the debounced level only moves on a strobe edge
   p_moves_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick) |-> $stable(level_q));

   // R2: a flip always lands on the value the input was showing
   p_flip_follows_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (level_q != $past(level_q)) |-> (level_q == $past(din)));

   // R2: the disagreement count never passes its limit
   p_count_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
      disagree_cnt < CW'(DB_TICKS));
endmodule

// File: rtl/mpq_judge.sv
module mpq_judge
   import mpq_pkg::*;
#(
   parameter int MIN_HIGH = 20,
   parameter int WINDOW   = 30
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic held,
   input  logic measuring,
   input  logic load_on,
   output logic press_pulse,
   output logic hold_timers,
   output logic abort_meas,
   output logic restart_meas
);
   localparam int HW = $clog2(MIN_HIGH + 1);
   localparam int WW = $clog2(WINDOW + 1);

   if (MIN_HIGH < 1) begin : g_bad_min
      $error("mpq_judge: MIN_HIGH must be at least 1");
   end
   if (WINDOW < MIN_HIGH) begin : g_bad_window
      $error("mpq_judge: WINDOW must not be shorter than MIN_HIGH");
   end

   qual_state_t   st_q, st_d;
   logic [HW-1:0] hi_q, hi_d, hi_sat;
   logic [WW-1:0] wnd_q, wnd_d;
   logic          pulse_q, pulse_d;
   logic          restart_q, restart_d;

   assign hi_sat = (hi_q == HW'(MIN_HIGH)) ? hi_q : hi_q + 1'b1;

   always_comb begin
      st_d      = st_q;
      hi_d      = hi_q;
      wnd_d     = wnd_q;
      pulse_d   = 1'b0;
      restart_d = 1'b0;
      unique case (st_q)
         Q_IDLE: begin
            if (held) begin
               hi_d  = '0;
               wnd_d = '0;
               st_d  = measuring ? Q_ABORT : Q_OBSERVE;
            end
         end
         Q_OBSERVE: begin
            if (measuring && held) begin
               st_d = Q_ABORT;
            end else if (tick) begin
               wnd_d = wnd_q + 1'b1;
               if (held) hi_d = hi_sat;
               if (held && hi_sat == HW'(MIN_HIGH)) begin
                  if (load_on) begin
                     st_d = Q_SPENT;
                  end else begin
                     st_d    = Q_ARMED;
                     pulse_d = 1'b1;
                  end
               end else if (wnd_q == WW'(WINDOW - 1)) begin
                  st_d = Q_SPENT;
               end
            end
         end
         Q_ARMED: begin
            if (!held) st_d = Q_IDLE;
         end
         Q_SPENT: begin
            if (measuring && held) st_d = Q_ABORT;
            else if (!held)        st_d = Q_IDLE;
         end
         Q_ABORT: begin
            if (!held) begin
               st_d      = Q_IDLE;
               restart_d = 1'b1;
            end
         end
         default: st_d = Q_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= Q_IDLE;
         hi_q      <= '0;
         wnd_q     <= '0;
         pulse_q   <= 1'b0;
         restart_q <= 1'b0;
      end else begin
         st_q      <= st_d;
         hi_q      <= hi_d;
         wnd_q     <= wnd_d;
         pulse_q   <= pulse_d;
         restart_q <= restart_d;
      end
   end

   assign press_pulse  = pulse_q;
   assign restart_meas = restart_q;
   assign hold_timers  = (st_q == Q_ARMED);
   assign abort_meas   = (st_q == Q_ABORT);

   p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      press_pulse |=> !press_pulse);

   p_pulse_needs_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      press_pulse |-> $past(held) && $past(tick));

   p_high_count_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hi_q <= HW'(MIN_HIGH));

   p_window_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wnd_q <= WW'(WINDOW));

   p_pulse_arms_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      press_pulse |-> hold_timers);

   p_hold_drops_on_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_timers && !held) |=> !hold_timers);

   p_no_pulse_when_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
      press_pulse |-> !$past(load_on));

   p_abort_blocks_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      abort_meas |-> !press_pulse && !hold_timers);

   p_restart_follows_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
      restart_meas |-> $past(abort_meas) && !abort_meas);
endmodule

// File: rtl/manual_press_qualifier.sv
module manual_press_qualifier #(
   parameter int SYNC_STAGES    = 2,
   parameter int DEBOUNCE_TICKS = 3,
   parameter int MIN_HIGH_TICKS = 20,
   parameter int WINDOW_TICKS   = 30
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic trig_raw,
   input  logic measuring,
   input  logic load_on,
   output logic press_pulse,
   output logic trig_held,
   output logic hold_timers,
   output logic abort_meas,
   output logic restart_meas
);
   logic trig_sync;
   logic held_lvl;

   mpq_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (trig_raw),
      .q     (trig_sync)
   );

   mpq_debounce #(
      .DB_TICKS (DEBOUNCE_TICKS)
   ) u_debounce (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .din   (trig_sync),
      .level (held_lvl)
   );

   mpq_judge #(
      .MIN_HIGH (MIN_HIGH_TICKS),
      .WINDOW   (WINDOW_TICKS)
   ) u_judge (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .held         (held_lvl),
      .measuring    (measuring),
      .load_on      (load_on),
      .press_pulse  (press_pulse),
      .hold_timers  (hold_timers),
      .abort_meas   (abort_meas),
      .restart_meas (restart_meas)
   );

   assign trig_held = held_lvl;

   // R1: nothing is reported while reset is applied
   always_comb begin
      if (!rst_n) begin
         a_quiet_in_reset_r1: assert (!press_pulse && !held_lvl && !hold_timers
                                      && !abort_meas && !restart_meas);
      end
   end
endmodule

// File: tb/manual_press_qualifier_test.sv
`timescale 1ns/1ps
module manual_press_qualifier_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic trig_raw = 1'b0;
   logic measuring = 1'b0;
   logic load_on = 1'b0;
   logic press_pulse, trig_held, hold_timers, abort_meas, restart_meas;

   int errors = 0;
   int checks = 0;
   bit done_flag = 1'b0;

   manual_press_qualifier uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .trig_raw(trig_raw),
      .measuring(measuring), .load_on(load_on), .press_pulse(press_pulse),
      .trig_held(trig_held), .hold_timers(hold_timers),
      .abort_meas(abort_meas), .restart_meas(restart_meas)
   );

   always #2.5 clk = ~clk;

   // strobe: one clock high out of every four
   logic [1:0] div = 2'd0;
   always @(posedge clk) begin
      div  <= div + 2'd1;
      tick <= (div == 2'd3);
   end

   // port monitor
   int pulse_cnt = 0, restart_cnt = 0, rise_cnt = 0, hold_seen = 0;
   int lat_cnt = 0, last_lat = -1;
   logic held_prev = 1'b0;
   always @(posedge clk) begin
      held_prev <= trig_held;
      if (trig_held && !held_prev) rise_cnt <= rise_cnt + 1;
      if (!trig_held)              lat_cnt <= 0;
      else if (tick)               lat_cnt <= lat_cnt + 1;
      if (press_pulse) begin
         pulse_cnt <= pulse_cnt + 1;
         last_lat  <= lat_cnt;
      end
      if (restart_meas) restart_cnt <= restart_cnt + 1;
      if (hold_timers)  hold_seen <= hold_seen + 1;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      repeat (4 * n) @(negedge clk);
   endtask

   task automatic press(input int n);
      @(negedge clk) trig_raw = 1'b1;
      wait_ticks(n);
      @(negedge clk) trig_raw = 1'b0;
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      check(!press_pulse && !trig_held && !hold_timers && !abort_meas && !restart_meas,
            "R1 outputs in reset", {press_pulse, trig_held, hold_timers, abort_meas, restart_meas}, 0);
      @(negedge clk) rst_n = 1'b1;
      wait_ticks(4);
      check(!trig_held && !hold_timers && !abort_meas, "R1 idle after reset",
            {trig_held, hold_timers, abort_meas}, 0);
   endtask

   task automatic t_glitch_high;
      int r0 = rise_cnt, p0 = pulse_cnt;
      press(1);
      wait_ticks(6);
      check(rise_cnt == r0, "R2 one-strobe high glitch rejected", rise_cnt - r0, 0);
      check(pulse_cnt == p0, "R3 glitch gives no press", pulse_cnt - p0, 0);
   endtask

   task automatic t_long_press;
      int p0 = pulse_cnt;
      @(negedge clk) trig_raw = 1'b1;
      wait_ticks(30);
      check(pulse_cnt == p0 + 1, "R3 held press accepted", pulse_cnt - p0, 1);
      check(last_lat == 20, "R4 strobes from debounced rise to pulse", last_lat, 20);
      check(hold_timers == 1'b1, "R5 counters held after press", hold_timers, 1);
      @(negedge clk) trig_raw = 1'b0;
      wait_ticks(1);
      @(negedge clk) trig_raw = 1'b1;
      wait_ticks(1);
      check(trig_held == 1'b1, "R2 one-strobe low glitch rejected", trig_held, 1);
      wait_ticks(10);
      check(hold_timers == 1'b1, "R5 long hold extends on-time", hold_timers, 1);
      check(pulse_cnt == p0 + 1, "R8 single pulse per press", pulse_cnt - p0, 1);
      @(negedge clk) trig_raw = 1'b0;
      wait_ticks(6);
      check(hold_timers == 1'b0 && trig_held == 1'b0, "R5 hold drops on release",
            {hold_timers, trig_held}, 0);
   endtask

   task automatic t_short_press;
      int p0 = pulse_cnt, h0 = hold_seen;
      press(10);
      wait_ticks(35);
      check(pulse_cnt == p0, "R3 short press rejected", pulse_cnt - p0, 0);
      check(hold_seen == h0, "R3 short press never arms hold", hold_seen - h0, 0);
   endtask

   task automatic t_split_press;
      int p0 = pulse_cnt, r0 = rise_cnt;
      press(8);
      wait_ticks(14);
      press(30);
      wait_ticks(8);
      check(rise_cnt == r0 + 2, "R2 split press seen as two rises", rise_cnt - r0, 2);
      check(pulse_cnt == p0, "R3 window closes before count", pulse_cnt - p0, 0);
      check(hold_timers == 1'b0, "R3 no hold after rejected window", hold_timers, 0);
   endtask

   task automatic t_load_on;
      int p0 = pulse_cnt, h0 = hold_seen;
      @(negedge clk) load_on = 1'b1;
      press(30);
      wait_ticks(8);
      check(pulse_cnt == p0, "R6 press ignored while load on", pulse_cnt - p0, 0);
      check(hold_seen == h0, "R6 hold never armed while load on", hold_seen - h0, 0);
      @(negedge clk) load_on = 1'b0;
   endtask

   task automatic t_measuring;
      int p0 = pulse_cnt, q0 = restart_cnt;
      @(negedge clk) measuring = 1'b1;
      @(negedge clk) trig_raw = 1'b1;
      wait_ticks(8);
      check(abort_meas == 1'b1, "R7 abort raised during measurement", abort_meas, 1);
      check(restart_cnt == q0, "R7 no restart while pressed", restart_cnt - q0, 0);
      wait_ticks(20);
      check(pulse_cnt == p0 && hold_timers == 1'b0, "R7 press not accepted while measuring",
            pulse_cnt - p0, 0);
      @(negedge clk) trig_raw = 1'b0;
      wait_ticks(6);
      check(abort_meas == 1'b0, "R7 abort cleared on release", abort_meas, 0);
      check(restart_cnt == q0 + 1, "R7 one restart request", restart_cnt - q0, 1);
      @(negedge clk) measuring = 1'b0;
   endtask

   task automatic t_second_press;
      int p0 = pulse_cnt;
      press(25);
      wait_ticks(8);
      check(pulse_cnt == p0 + 1, "R8 second press one pulse", pulse_cnt - p0, 1);
      check(last_lat == 20, "R4 latency on second press", last_lat, 20);
      check(hold_timers == 1'b0, "R5 hold cleared after release", hold_timers, 0);
   endtask

   task automatic finish_run;
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #1000000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      t_reset();
      t_glitch_high();
      t_long_press();
      t_short_press();
      t_split_press();
      t_load_on();
      t_measuring();
      t_second_press();
      finish_run();
   end
endmodule